// File: doc/BRIEF.md
# Scalar Memory Bank Conflict Hold

This block tracks the last three references that have entered the memory access path of an interleaved memory. It holds them in a three-stage pipeline of ranks: rank A is the newest, then rank B, and rank C is the oldest. An accepted reference enters rank A on the clock edge after it is presented. On each later edge it moves one rank further. A scalar or I/O reference is first compared against the banks held in the three ranks. The block then reports how many extra clock periods the reference must wait before it may enter the pipeline.

The penalty depends on which rank holds the clashing bank. An older rank clears sooner, so a clash with rank C costs one period, with rank B two, and with rank A three. If several ranks clash, the largest penalty applies. During the penalty the ranks keep advancing and empty slots (bubbles) enter rank A. The delayed reference is parked and enters rank A when the penalty ends. New requests are refused while the block reports busy.

Top module: `smbc_bank_hold`

## Requirements
- R1: While reset is high and in the cycle after it is released, `rank_valid` is 0, `req_busy` is low and `res_valid` is low.
- R2: A reference accepted without delay has its address in rank A (index 0 of `rank_valid`/`rank_addr`) after the next rising edge. It is in rank B (index 1) one edge later and in rank C (index 2) one edge after that. An empty slot moves through the ranks the same way.
- R3: The bank of an address is its low `BANK_BITS` bits (default 4, giving 16 banks). A rank conflicts when it is valid and its bank equals the bank of the new reference. Invalid ranks never conflict. `res_hits` bit i reports a conflict with rank i (bit 0 = A, bit 1 = B, bit 2 = C).
- R4: The edge after a request is accepted, `res_valid` pulses high for one cycle. With it, `res_delay` gives the penalty: 1 for a conflict with rank C only, 2 for rank B, 3 for rank A, and 0 when there is no conflict.
- R5: When several ranks conflict at once, `res_delay` is the largest of their penalties, and `res_hits` shows every conflicting rank.
- R6: Only `req_kind` 2'b01 (scalar) and 2'b10 (I/O) are checked. Kinds 2'b00 and 2'b11 always give `res_delay` 0 and `res_hits` 0, and enter rank A directly.
- R7: A reference with penalty d>0 makes `req_busy` high for exactly d cycles after the edge that accepts it. Bubbles enter rank A during the first d edges, and the reference enters rank A at the edge that ends the busy period. A request presented while `req_busy` is high is ignored: it produces no `res_valid` and does not enter the ranks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_kind | input | 2 | 01 scalar, 10 I/O, 00/11 unchecked |
| req_addr | input | ADDR_W | Word address of the reference |
| req_busy | output | 1 | A delayed reference is parked; requests are refused |
| res_valid | output | 1 | One-cycle pulse reporting the penalty of the last accepted reference |
| res_delay | output | 2 | Penalty in clock periods (0 to 3) |
| res_hits | output | 3 | Conflicting ranks, bit 0 = A, bit 2 = C |
| rank_valid | output | 3 | Occupancy of ranks A, B, C |
| rank_addr | output | 3*ADDR_W | Rank addresses; rank i at bits [i*ADDR_W +: ADDR_W] |

## Verification
The interesting collision is between penalty detection and the continuous movement of the ranks. A new request is compared against rank contents on the same edge where those contents shift. The end of a busy period also coincides with a request arriving on the very cycle the parked reference enters rank A. Directed sequences build both cases: back-to-back and spaced references to one bank, which set up single-rank and multi-rank clashes, and requests held during every cycle of a hold. Random traffic limited to four banks then repeats them many times. Every cycle, a bench model built from the requirements predicts the penalty, the hit mask, the busy flag and the exact rank occupancy. The bench compares each of these against the design.

// File: rtl/smbc_pkg.sv
package smbc_pkg;

    localparam int NUM_RANKS = 3;
    localparam int DLY_W     = 2;

    typedef enum logic [1:0] {
        REF_OTHER  = 2'b00,
        REF_SCALAR = 2'b01,
        REF_IO     = 2'b10,
        REF_SPARE  = 2'b11
    } ref_kind_e;

    typedef logic [NUM_RANKS-1:0] rank_mask_t;
    typedef logic [DLY_W-1:0]     delay_t;

    typedef struct packed {
        logic   active;
        delay_t remain;
    } hold_state_t;

    typedef struct packed {
        logic       valid;
        delay_t     delay;
        rank_mask_t hits;
    } result_t;

    // Newest rank (index 0) is the most expensive to wait out.
    function automatic delay_t rank_cost(input int idx);
        return delay_t'(NUM_RANKS - idx);
    endfunction

    function automatic delay_t worst_delay(input rank_mask_t hits);
        delay_t d;
        d = '0;
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if (hits[i]) d = rank_cost(i);
        end
        return d;
    endfunction

    function automatic logic kind_checked(input logic [1:0] kind);
        return (kind == REF_SCALAR) || (kind == REF_IO);
    endfunction

endpackage

// File: rtl/smbc_rank_pipe.sv
module smbc_rank_pipe
    import smbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM    = NUM_RANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic [ADDR_W-1:0]     in_addr,
    output logic [NUM-1:0]        out_vld,
    output logic [NUM*ADDR_W-1:0] out_addr
);

    logic [NUM-1:0]    vld_q;
    logic [ADDR_W-1:0] addr_q [NUM];

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_rank
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[i]  <= 1'b0;
                        addr_q[i] <= '0;
                    end else begin
                        vld_q[i]  <= in_vld;
                        addr_q[i] <= in_vld ? in_addr : '0;
                    end
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[i]  <= 1'b0;
                        addr_q[i] <= '0;
                    end else begin
                        vld_q[i]  <= vld_q[i-1];
                        addr_q[i] <= addr_q[i-1];
                    end
                end
            end
            assign out_addr[i*ADDR_W +: ADDR_W] = addr_q[i];
        end
    endgenerate

    assign out_vld = vld_q;

endmodule

// File: rtl/smbc_conflict.sv
module smbc_conflict
    import smbc_pkg::*;
#(
    parameter int BANK_BITS = 4,
    parameter int NUM       = NUM_RANKS
) (
    input  logic                     chk_en,
    input  logic [BANK_BITS-1:0]     new_bank,
    input  logic [NUM-1:0]           rank_vld,
    input  logic [NUM*BANK_BITS-1:0] rank_bank,
    output rank_mask_t               hits,
    output delay_t                   delay
);

    generate
        for (genvar i = 0; i < NUM; i++) begin : g_cmp
            assign hits[i] = chk_en && rank_vld[i]
                             && (rank_bank[i*BANK_BITS +: BANK_BITS] == new_bank);
        end
    endgenerate

    assign delay = worst_delay(hits);

endmodule

// File: rtl/smbc_hold_ctl.sv
module smbc_hold_ctl
    import smbc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  rank_mask_t        conf_hits,
    input  delay_t            conf_delay,
    output logic              chk_en,
    output logic              load_vld,
    output logic [ADDR_W-1:0] load_addr,
    output logic              busy,
    output result_t           result
);

    hold_state_t       st_q;
    logic [ADDR_W-1:0] held_q;
    logic              accept;
    delay_t            eff_delay;

    assign accept    = req_valid && !st_q.active;
    assign chk_en    = accept && kind_checked(req_kind);
    assign eff_delay = chk_en ? conf_delay : '0;

    always_comb begin
        if (st_q.active) begin
            load_vld  = (st_q.remain == '0);
            load_addr = held_q;
        end else begin
            load_vld  = accept && (eff_delay == '0);
            load_addr = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            held_q <= '0;
            result <= '0;
        end else if (st_q.active) begin
            result <= '0;
            if (st_q.remain == '0) st_q.active <= 1'b0;
            else                   st_q.remain <= st_q.remain - 1'b1;
        end else if (accept) begin
            result.valid <= 1'b1;
            result.delay <= eff_delay;
            result.hits  <= chk_en ? conf_hits : '0;
            if (eff_delay != '0) begin
                st_q.active <= 1'b1;
                st_q.remain <= eff_delay - 1'b1;
                held_q      <= req_addr;
            end
        end else begin
            result <= '0;
        end
    end

    assign busy = st_q.active;

endmodule

// File: rtl/smbc_bank_hold.sv
module smbc_bank_hold
    import smbc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BANK_BITS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_kind,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        req_busy,
    output logic                        res_valid,
    output logic [DLY_W-1:0]            res_delay,
    output logic [NUM_RANKS-1:0]        res_hits,
    output logic [NUM_RANKS-1:0]        rank_valid,
    output logic [NUM_RANKS*ADDR_W-1:0] rank_addr
);

    localparam int BANK_VEC_W = NUM_RANKS * BANK_BITS;

    logic                  chk_en;
    logic                  load_vld;
    logic [ADDR_W-1:0]     load_addr;
    rank_mask_t            conf_hits;
    delay_t                conf_delay;
    result_t               result;
    logic [BANK_VEC_W-1:0] rank_bank;

    generate
        for (genvar i = 0; i < NUM_RANKS; i++) begin : g_bank
            assign rank_bank[i*BANK_BITS +: BANK_BITS] = rank_addr[i*ADDR_W +: BANK_BITS];
        end
    endgenerate

    smbc_hold_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_addr   (req_addr),
        .conf_hits  (conf_hits),
        .conf_delay (conf_delay),
        .chk_en     (chk_en),
        .load_vld   (load_vld),
        .load_addr  (load_addr),
        .busy       (req_busy),
        .result     (result)
    );

    smbc_conflict #(.BANK_BITS(BANK_BITS), .NUM(NUM_RANKS)) u_conf (
        .chk_en    (chk_en),
        .new_bank  (req_addr[BANK_BITS-1:0]),
        .rank_vld  (rank_valid),
        .rank_bank (rank_bank),
        .hits      (conf_hits),
        .delay     (conf_delay)
    );

    smbc_rank_pipe #(.ADDR_W(ADDR_W), .NUM(NUM_RANKS)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (load_vld),
        .in_addr  (load_addr),
        .out_vld  (rank_valid),
        .out_addr (rank_addr)
    );

    assign res_valid = result.valid;
    assign res_delay = result.delay;
    assign res_hits  = result.hits;

endmodule

// File: rtl/smbc_bank_hold_chk.sv
module smbc_bank_hold_chk #(
    parameter int ADDR_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic                req_busy,
    input logic                res_valid,
    input logic [1:0]          res_delay,
    input logic [2:0]          res_hits,
    input logic [2:0]          rank_valid,
    input logic [3*ADDR_W-1:0] rank_addr
);

    assert_rank_shift_R2: assert property (@(posedge clk) disable iff (rst)
        rank_valid[2:1] == $past(rank_valid[1:0]));

    assert_addr_shift_R2: assert property (@(posedge clk) disable iff (rst)
        rank_valid[1] |-> rank_addr[ADDR_W +: ADDR_W] == $past(rank_addr[0 +: ADDR_W]));

    assert_oldest_only_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hits == 3'b100) |-> res_delay == 2'd1);

    assert_newest_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hits[0]) |-> res_delay == 2'd3);

    assert_unchecked_kind_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_busy && (req_kind == 2'b00 || req_kind == 2'b11))
        |=> (res_valid && res_delay == 2'd0 && res_hits == 3'b000));

    assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_busy) |-> (res_valid && res_delay != 2'd0));

    assert_busy_refuses_R7: assert property (@(posedge clk) disable iff (rst)
        req_busy |=> !res_valid);

endmodule

bind smbc_bank_hold smbc_bank_hold_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_busy   (req_busy),
    .res_valid  (res_valid),
    .res_delay  (res_delay),
    .res_hits   (res_hits),
    .rank_valid (rank_valid),
    .rank_addr  (rank_addr)
);

// File: tb/sim_smbc_bank_hold.sv
module sim_smbc_bank_hold;

    localparam int AW = 12;
    localparam int BB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          req_busy, res_valid;
    logic [1:0]    res_delay;
    logic [2:0]    res_hits, rank_valid;
    logic [3*AW-1:0] rank_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    smbc_bank_hold #(.ADDR_W(AW), .BANK_BITS(BB)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_busy(req_busy), .res_valid(res_valid),
        .res_delay(res_delay), .res_hits(res_hits), .rank_valid(rank_valid),
        .rank_addr(rank_addr)
    );

    // Bench model state, written from the requirements
    logic [2:0]    m_vld;
    logic [AW-1:0] m_addr [3];
    logic          m_hold;
    int            m_cnt;
    logic [AW-1:0] m_held;
    logic          e_rv;
    logic [1:0]    e_dly;
    logic [2:0]    e_hits;
    string         e_tag;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] model_delay(input logic [2:0] h);
        if (h[0]) return 2'd3;
        if (h[1]) return 2'd2;
        if (h[2]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic model_reset();
        m_vld = '0;
        for (int i = 0; i < 3; i++) m_addr[i] = '0;
        m_hold = 1'b0; m_cnt = 0; m_held = '0;
        e_rv = 1'b0; e_dly = '0; e_hits = '0; e_tag = "R4";
    endtask

    task automatic compare_all();
        chk("R7 busy", int'(req_busy), int'(m_hold));
        chk("R7 res_valid", int'(res_valid), int'(e_rv));
        if (e_rv) begin
            chk({e_tag, " delay"}, int'(res_delay), int'(e_dly));
            chk("R3 hits", int'(res_hits), int'(e_hits));
        end
        chk("R2 rank_valid", int'(rank_valid), int'(m_vld));
        for (int i = 0; i < 3; i++)
            if (m_vld[i]) chk("R2 rank_addr", int'(rank_addr[i*AW +: AW]), int'(m_addr[i]));
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] a);
        logic [2:0] h;
        logic       new_vld;
        logic [AW-1:0] new_addr;
        logic       chkd;
        @(negedge clk);
        compare_all();
        req_valid = v; req_kind = k; req_addr = a;
        new_vld = 1'b0; new_addr = '0;
        e_rv = 1'b0; e_dly = '0; e_hits = '0;
        if (m_hold) begin
            if (m_cnt == 0) begin
                new_vld = 1'b1; new_addr = m_held; m_hold = 1'b0;
            end else m_cnt--;
        end else if (v) begin
            chkd = (k == 2'b01) || (k == 2'b10);
            h = '0;
            for (int i = 0; i < 3; i++)
                h[i] = chkd && m_vld[i] && (m_addr[i][BB-1:0] == a[BB-1:0]);
            e_rv = 1'b1; e_hits = h; e_dly = model_delay(h);
            e_tag = !chkd ? "R6" : ($countones(h) > 1 ? "R5" : "R4");
            if (e_dly == 0) begin
                new_vld = 1'b1; new_addr = a;
            end else begin
                m_hold = 1'b1; m_cnt = int'(e_dly) - 1; m_held = a;
            end
        end
        m_vld = {m_vld[1:0], new_vld};
        m_addr[2] = m_addr[1]; m_addr[1] = m_addr[0]; m_addr[0] = new_addr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset busy", int'(req_busy), 0);
        chk("R1 reset res_valid", int'(res_valid), 0);
        chk("R1 reset ranks", int'(rank_valid), 0);
        rst = 1'b0;

        // R4: clash with rank A -> 3, request offered during the hold (R7)
        step(1'b1, 2'b01, 12'h005);
        step(1'b1, 2'b01, 12'h105);
        step(1'b1, 2'b01, 12'h0A9);
        step(1'b1, 2'b10, 12'h0A9);
        idle(5);
        // R4: clash with rank B -> 2
        step(1'b1, 2'b01, 12'h007);
        idle(1);
        step(1'b1, 2'b10, 12'h017);
        idle(5);
        // R4: clash with rank C -> 1
        step(1'b1, 2'b01, 12'h00C);
        idle(2);
        step(1'b1, 2'b01, 12'h31C);
        idle(5);
        // R6: unchecked kinds pass straight through despite a clash
        step(1'b1, 2'b00, 12'h003);
        step(1'b1, 2'b11, 12'h013);
        // R5: clash with ranks A and B at once -> 3
        step(1'b1, 2'b01, 12'h023);
        idle(5);
        // R3: bank equal only in the upper bits is no clash; empty ranks ignored
        step(1'b1, 2'b01, 12'h040);
        step(1'b1, 2'b01, 12'h041);
        idle(4);
        step(1'b1, 2'b01, 12'h000);
        idle(4);

        // Random traffic folded onto four banks to provoke clashes
        for (int n = 0; n < 3000; n++) begin
            logic v;
            logic [1:0] k;
            logic [AW-1:0] a;
            v = ($urandom % 4) != 0;
            k = 2'($urandom % 4);
            a = {8'($urandom), 4'($urandom % 4)};
            step(v, k, a);
        end
        idle(6);
        @(negedge clk);
        compare_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule